// File: doc/BRIEF.md
# Banked Register File Read Arbiter

This block sits in front of a physical register file that is split into several banks, each with a small number of local read ports. Every cycle it receives the source register indices of a decode group of up to four instructions (two sources each, so eight global read ports). It maps every needed read to a bank, gives each distinct register a local port of that bank, and lets reads of the same register share one local port. It then routes the local port data to the global ports. It also grants the longest program-order prefix of the group that fits the port budget.

When a read cannot get a port, the instruction that owns it and every younger instruction in the group are stalled. The stalled remainder is held inside the block and presented again on the next cycle, ahead of any new decode group. New groups are refused until the whole remainder has been granted. The storage behind the ports is a plain behavioural array. It has a parameterised number of write ports, used only to load values.

Control is a two-state machine. `ST_ACCEPT` arbitrates the group on the input pins and `ST_REPLAY` arbitrates the held remainder. Four transitions are defined. ACCEPT→ACCEPT applies when the whole input group is granted, and ACCEPT→REPLAY when part of it stalls. REPLAY→REPLAY applies when part of the remainder stalls again, and REPLAY→ACCEPT when the remainder is fully granted.

Top module: `rf_read_arbiter`

## Requirements
- R1: A register's bank is given by the low log2(banks) bits of its index. For every granted read, `rd_bank` reports that bank.
- R2: For every granted read, `rd_data` carries the stored value of the requested register, taken through a local port of its bank.
- R3: Within one bank in one cycle, granted reads of different registers use different local ports, so no more than the per-bank port count of distinct registers is read per bank.
- R4: Granted reads of the same register report the same bank and the same local port, and they count once against the bank's budget.
- R5: A source whose `in_need` bit is 0 uses no port. Its `rd_vld` is 0 and its `rd_data` is 0, and the same holds for every source of an instruction that is not granted.
- R6: Grants form a program-order prefix: the first valid instruction that cannot be served is refused, and so is every later instruction in the group, while all earlier valid ones are granted.
- R7: `stall` is 1 exactly when some valid instruction of the arbitrated group is not granted. `acc_rdy` is then 0 in the next cycle, and it returns to 1 the cycle after the remainder has been fully granted.
- R8: While `acc_rdy` is 0, the block arbitrates the held remainder (same indices, same need bits), ignores the input pins, and never grants an instruction again once it has been granted.
- R9: The oldest instruction of a held remainder is always granted, even when both of its sources are different registers in one bank.
- R10: After reset, `acc_rdy` is 1, nothing is granted or stalled with no valid input, and every stored register reads as 0.
- R11: A write port with `wr_en` set updates the register at `wr_idx` on the clock edge. When two ports write the same register, the higher-numbered port wins.
- R12: An instruction slot whose `in_vld` bit is 0 is never granted, uses no ports and does not stop later instructions from being granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 4 | Valid bit per instruction slot, bit 0 oldest |
| in_need | input | 8 | Read needed per source; bits 2i and 2i+1 belong to instruction i |
| in_idx | input | 48 | Physical register index per source, 6 bits each, source 0 in the low bits |
| wr_en | input | 2 | Write enable per write port |
| wr_idx | input | 12 | Register index per write port |
| wr_data | input | 64 | Data per write port |
| acc_rdy | output | 1 | 1 when the input group is being arbitrated |
| grant | output | 4 | Instruction granted this cycle |
| stall | output | 1 | Some valid instruction of the arbitrated group was refused |
| rd_vld | output | 8 | Global read port carries granted data |
| rd_bank | output | 24 | Bank feeding each global port, 3 bits each |
| rd_lport | output | 8 | Local port of that bank feeding each global port, 1 bit each |
| rd_data | output | 256 | Read data per global port, 32 bits each |

## Verification
A corrupted held remainder shows at the ports in the first replay cycle. The grant vector, bank selects and read data would then belong to the wrong instructions or indices, and instructions granted earlier would come back. A wrong per-bank port count or a missed sharing match shows up in the same cycle. In that case two different registers report the same local port, or a group that fits the budget is stalled, or one that does not fit is granted beyond its prefix. A state register stuck in either state shows up one cycle after a stall, as an `acc_rdy` that does not fall, or as a replay that never ends.

// File: rtl/rf_arb_pkg.sv
`timescale 1ns/1ps
package rf_arb_pkg;

    typedef enum logic [0:0] {
        ST_ACCEPT = 1'b0,
        ST_REPLAY = 1'b1
    } arb_state_e;

endpackage

// File: rtl/rf_arb_alloc.sv
`timescale 1ns/1ps
module rf_arb_alloc #(
    parameter int NI     = 4,
    parameter int SPI    = 2,
    parameter int NB     = 8,
    parameter int P      = 2,
    parameter int PREG_W = 6,
    localparam int NG    = NI * SPI,
    localparam int BW    = $clog2(NB),
    localparam int LW    = (P > 1) ? $clog2(P) : 1,
    localparam int RW    = PREG_W - BW,
    localparam int CW    = $clog2(P + 1)
) (
    input  logic [NI-1:0]                   act_vld,
    input  logic [NG-1:0]                   act_need,
    input  logic [NG-1:0][PREG_W-1:0]       act_idx,
    output logic [NI-1:0]                   grant,
    output logic [NG-1:0]                   gp_use,
    output logic [NG-1:0][BW-1:0]           gp_bank,
    output logic [NG-1:0][LW-1:0]           gp_lport,
    output logic [NB-1:0][P-1:0]            lp_en,
    output logic [NB-1:0][P-1:0][RW-1:0]    lp_row
);

    // committed and tentative bank port occupancy
    logic [NB-1:0][P-1:0]          en_c, en_t;
    logic [NB-1:0][P-1:0][RW-1:0]  ox_c, ox_t;
    logic [NB-1:0][CW-1:0]         cnt_c, cnt_t;
    logic                          blocked, ok, hit;
    logic [BW-1:0]                 b;
    logic [LW-1:0]                 lp;
    logic [SPI-1:0][LW-1:0]        slp;

    always_comb begin
        en_c     = '0;
        ox_c     = '0;
        cnt_c    = '0;
        en_t     = '0;
        ox_t     = '0;
        cnt_t    = '0;
        blocked  = 1'b0;
        ok       = 1'b0;
        hit      = 1'b0;
        b        = '0;
        lp       = '0;
        slp      = '0;
        grant    = '0;
        gp_use   = '0;
        gp_bank  = '0;
        gp_lport = '0;
        for (int i = 0; i < NI; i++) begin
            if (act_vld[i] && !blocked) begin
                en_t  = en_c;
                ox_t  = ox_c;
                cnt_t = cnt_c;
                ok    = 1'b1;
                slp   = '0;
                for (int s = 0; s < SPI; s++) begin
                    if (act_need[i*SPI+s]) begin
                        b   = act_idx[i*SPI+s][BW-1:0];
                        hit = 1'b0;
                        lp  = '0;
                        // read sharing: reuse a port already reading this row
                        for (int p = 0; p < P; p++) begin
                            if (!hit && en_t[b][p] &&
                                ox_t[b][p] == act_idx[i*SPI+s][PREG_W-1:BW]) begin
                                hit = 1'b1;
                                lp  = LW'(p);
                            end
                        end
                        if (!hit) begin
                            if (cnt_t[b] < CW'(P)) begin
                                lp           = cnt_t[b][LW-1:0];
                                en_t[b][lp]  = 1'b1;
                                ox_t[b][lp]  = act_idx[i*SPI+s][PREG_W-1:BW];
                                cnt_t[b]     = cnt_t[b] + CW'(1);
                            end else begin
                                ok = 1'b0;
                            end
                        end
                        slp[s] = lp;
                    end
                end
                if (ok) begin
                    en_c     = en_t;
                    ox_c     = ox_t;
                    cnt_c    = cnt_t;
                    grant[i] = 1'b1;
                    for (int s = 0; s < SPI; s++) begin
                        if (act_need[i*SPI+s]) begin
                            gp_use[i*SPI+s]   = 1'b1;
                            gp_bank[i*SPI+s]  = act_idx[i*SPI+s][BW-1:0];
                            gp_lport[i*SPI+s] = slp[s];
                        end
                    end
                end else begin
                    blocked = 1'b1;
                end
            end
        end
    end

    assign lp_en  = en_c;
    assign lp_row = ox_c;

endmodule

// File: rtl/rf_arb_banks.sv
`timescale 1ns/1ps
module rf_arb_banks #(
    parameter int NB        = 8,
    parameter int P         = 2,
    parameter int NUM_PREGS = 64,
    parameter int DATA_W    = 32,
    parameter int NUM_WR    = 2,
    localparam int PREG_W   = $clog2(NUM_PREGS),
    localparam int BW       = $clog2(NB),
    localparam int RW       = PREG_W - BW,
    localparam int ROWS     = NUM_PREGS / NB
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_WR-1:0]                   wr_en,
    input  logic [NUM_WR-1:0][PREG_W-1:0]       wr_idx,
    input  logic [NUM_WR-1:0][DATA_W-1:0]       wr_data,
    input  logic [NB-1:0][P-1:0]                lp_en,
    input  logic [NB-1:0][P-1:0][RW-1:0]        lp_row,
    output logic [NB-1:0][P-1:0][DATA_W-1:0]    lp_data
);

    logic [DATA_W-1:0] mem [NB][ROWS];

    // later write ports override earlier ones on the same register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int bk = 0; bk < NB; bk++) begin
                for (int r = 0; r < ROWS; r++) begin
                    mem[bk][r] <= '0;
                end
            end
        end else begin
            for (int w = 0; w < NUM_WR; w++) begin
                if (wr_en[w]) begin
                    mem[wr_idx[w][BW-1:0]][wr_idx[w][PREG_W-1:BW]] <= wr_data[w];
                end
            end
        end
    end

    for (genvar gb = 0; gb < NB; gb++) begin : g_bank
        for (genvar gp = 0; gp < P; gp++) begin : g_lport
            assign lp_data[gb][gp] = lp_en[gb][gp] ? mem[gb][lp_row[gb][gp]] : '0;
        end
    end

endmodule

// File: rtl/rf_arb_route.sv
`timescale 1ns/1ps
module rf_arb_route #(
    parameter int NG     = 8,
    parameter int NB     = 8,
    parameter int P      = 2,
    parameter int PREG_W = 6,
    parameter int DATA_W = 32,
    localparam int BW    = $clog2(NB),
    localparam int LW    = (P > 1) ? $clog2(P) : 1
) (
    input  logic                                rst_n,
    input  logic [NG-1:0]                       gp_use,
    input  logic [NG-1:0][BW-1:0]               gp_bank,
    input  logic [NG-1:0][LW-1:0]               gp_lport,
    input  logic [NG-1:0][PREG_W-1:0]           act_idx,
    input  logic [NB-1:0][P-1:0][DATA_W-1:0]    lp_data,
    output logic [NG-1:0][DATA_W-1:0]           rd_data
);

    for (genvar g = 0; g < NG; g++) begin : g_gport
        assign rd_data[g] = gp_use[g] ? lp_data[gp_bank[g]][gp_lport[g]] : '0;

        for (genvar h = 0; h < NG; h++) begin : g_pair
            if (h > g) begin : g_chk
                always_comb begin
                    if (rst_n && gp_use[g] && gp_use[h] && gp_bank[g] == gp_bank[h]) begin
                        AST_DISTINCT_REG_PORT: assert (act_idx[g] == act_idx[h] ||
                                                       gp_lport[g] != gp_lport[h])
                            else $error("two registers on one local port"); // R3
                        AST_SHARED_REG_PORT: assert (act_idx[g] != act_idx[h] ||
                                                     gp_lport[g] == gp_lport[h])
                            else $error("shared register on two local ports"); // R4
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rf_read_arbiter.sv
`timescale 1ns/1ps
module rf_read_arbiter
    import rf_arb_pkg::*;
#(
    parameter int NUM_INSTR     = 4,
    parameter int SRC_PER_INSTR = 2,
    parameter int NUM_BANKS     = 8,
    parameter int BANK_PORTS    = 2,
    parameter int NUM_PREGS     = 64,
    parameter int DATA_W        = 32,
    parameter int NUM_WR        = 2,
    localparam int NUM_GP       = NUM_INSTR * SRC_PER_INSTR,
    localparam int PREG_W       = $clog2(NUM_PREGS),
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int LP_W         = (BANK_PORTS > 1) ? $clog2(BANK_PORTS) : 1,
    localparam int ROW_W        = PREG_W - BANK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_INSTR-1:0]        in_vld,
    input  logic [NUM_GP-1:0]           in_need,
    input  logic [NUM_GP*PREG_W-1:0]    in_idx,
    input  logic [NUM_WR-1:0]           wr_en,
    input  logic [NUM_WR*PREG_W-1:0]    wr_idx,
    input  logic [NUM_WR*DATA_W-1:0]    wr_data,
    output logic                        acc_rdy,
    output logic [NUM_INSTR-1:0]        grant,
    output logic                        stall,
    output logic [NUM_GP-1:0]           rd_vld,
    output logic [NUM_GP*BANK_W-1:0]    rd_bank,
    output logic [NUM_GP*LP_W-1:0]      rd_lport,
    output logic [NUM_GP*DATA_W-1:0]    rd_data
);

    arb_state_e                             state_q, state_d;
    logic [NUM_INSTR-1:0]                   hold_vld;
    logic [NUM_GP-1:0]                      hold_need;
    logic [NUM_GP-1:0][PREG_W-1:0]          hold_idx;

    logic [NUM_INSTR-1:0]                   act_vld;
    logic [NUM_GP-1:0]                      act_need;
    logic [NUM_GP-1:0][PREG_W-1:0]          act_idx;

    logic [NUM_INSTR-1:0]                   grant_c;
    logic                                   stall_c;
    logic [NUM_GP-1:0]                      gp_use;
    logic [NUM_GP-1:0][BANK_W-1:0]          gp_bank;
    logic [NUM_GP-1:0][LP_W-1:0]            gp_lport;
    logic [NUM_BANKS-1:0][BANK_PORTS-1:0]   lp_en;
    logic [NUM_BANKS-1:0][BANK_PORTS-1:0][ROW_W-1:0]  lp_row;
    logic [NUM_BANKS-1:0][BANK_PORTS-1:0][DATA_W-1:0] lp_data;
    logic [NUM_GP-1:0][DATA_W-1:0]          gp_data;
    logic [NUM_INSTR-1:0]                   after_miss;

    // the held remainder goes ahead of anything on the input pins
    always_comb begin
        if (state_q == ST_REPLAY) begin
            act_vld  = hold_vld;
            act_need = hold_need;
            act_idx  = hold_idx;
        end else begin
            act_vld  = in_vld;
            act_need = in_need;
            act_idx  = in_idx;
        end
    end

    rf_arb_alloc #(
        .NI     (NUM_INSTR),
        .SPI    (SRC_PER_INSTR),
        .NB     (NUM_BANKS),
        .P      (BANK_PORTS),
        .PREG_W (PREG_W)
    ) u_alloc (
        .act_vld  (act_vld),
        .act_need (act_need),
        .act_idx  (act_idx),
        .grant    (grant_c),
        .gp_use   (gp_use),
        .gp_bank  (gp_bank),
        .gp_lport (gp_lport),
        .lp_en    (lp_en),
        .lp_row   (lp_row)
    );

    rf_arb_banks #(
        .NB        (NUM_BANKS),
        .P         (BANK_PORTS),
        .NUM_PREGS (NUM_PREGS),
        .DATA_W    (DATA_W),
        .NUM_WR    (NUM_WR)
    ) u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .lp_en   (lp_en),
        .lp_row  (lp_row),
        .lp_data (lp_data)
    );

    rf_arb_route #(
        .NG     (NUM_GP),
        .NB     (NUM_BANKS),
        .P      (BANK_PORTS),
        .PREG_W (PREG_W),
        .DATA_W (DATA_W)
    ) u_route (
        .rst_n    (rst_n),
        .gp_use   (gp_use),
        .gp_bank  (gp_bank),
        .gp_lport (gp_lport),
        .act_idx  (act_idx),
        .lp_data  (lp_data),
        .rd_data  (gp_data)
    );

    assign stall_c = |(act_vld & ~grant_c);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCEPT: state_d = stall_c ? ST_REPLAY : ST_ACCEPT;
            ST_REPLAY: state_d = stall_c ? ST_REPLAY : ST_ACCEPT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACCEPT;
        end else begin
            state_q <= state_d;
        end
    end

    // held remainder
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld  <= '0;
            hold_need <= '0;
            hold_idx  <= '0;
        end else if (stall_c) begin
            hold_vld  <= act_vld & ~grant_c;
            hold_need <= act_need;
            hold_idx  <= act_idx;
        end
    end

    // outputs
    always_comb begin
        acc_rdy  = (state_q == ST_ACCEPT);
        grant    = grant_c;
        stall    = stall_c;
        rd_vld   = gp_use;
        rd_bank  = gp_bank;
        rd_lport = gp_lport;
        rd_data  = gp_data;
    end

    always_comb begin
        after_miss = '0;
        for (int i = 1; i < NUM_INSTR; i++) begin
            after_miss[i] = after_miss[i-1] | (act_vld[i-1] & ~grant_c[i-1]);
        end
    end

    AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_c & after_miss) == '0); // R6
    AST_STALL_BLOCKS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        stall_c |=> !acc_rdy); // R7
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        stall_c |=> ((grant_c & $past(grant_c)) == '0)); // R8
    AST_HEAD_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY) |-> (grant_c != '0)); // R9
    AST_UNNEEDED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_use & ~act_need) == '0); // R5

endmodule

// File: tb/rf_read_arbiter_bench.sv
`timescale 1ns/1ps
module rf_read_arbiter_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   in_vld = '0;
    logic [7:0]   in_need = '0;
    logic [47:0]  in_idx = '0;
    logic [1:0]   wr_en = '0;
    logic [11:0]  wr_idx = '0;
    logic [63:0]  wr_data = '0;
    logic         acc_rdy;
    logic [3:0]   grant;
    logic         stall;
    logic [7:0]   rd_vld;
    logic [23:0]  rd_bank;
    logic [7:0]   rd_lport;
    logic [255:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rf_read_arbiter u_rf_read_arbiter (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_need(in_need), .in_idx(in_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .acc_rdy(acc_rdy),
        .grant(grant), .stall(stall), .rd_vld(rd_vld), .rd_bank(rd_bank),
        .rd_lport(rd_lport), .rd_data(rd_data)
    );

    // {vld, need, indices (source 7 .. source 0, two octal digits each), first grant}
    localparam logic [63:0] VEC [6] = '{
        {4'hF, 8'hFF, 48'o7766554433221100, 4'hF},
        {4'hF, 8'hFF, 48'o0605040302211101, 4'h1},
        {4'hF, 8'hFF, 48'o2313231323132313, 4'hF},
        {4'hF, 8'hCB, 48'o2515443405241404, 4'h7},
        {4'hF, 8'hFF, 48'o0201002313031303, 4'h3},
        {4'h0, 8'hFF, 48'o7766554433221100, 4'h0}
    };

    function automatic logic [31:0] regval(input int r);
        return 32'h5A00_0000 + 32'(r) * 32'h0001_0203;
    endfunction

    // prefix grant from counting distinct registers per bank
    function automatic logic [3:0] model(input logic [3:0] v, input logic [7:0] n,
                                         input logic [47:0] ix);
        logic [7:0] taken, cand;
        logic [3:0] gr;
        logic       stop, first, over;
        int         cnt [8];
        taken = '0; gr = '0; stop = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (v[i] && !stop) begin
                cand = taken;
                cand[2*i]   = n[2*i];
                cand[2*i+1] = n[2*i+1];
                for (int b = 0; b < 8; b++) cnt[b] = 0;
                for (int a = 0; a < 8; a++) begin
                    if (cand[a]) begin
                        first = 1'b1;
                        for (int c = 0; c < a; c++)
                            if (cand[c] && ix[c*6 +: 6] == ix[a*6 +: 6]) first = 1'b0;
                        if (first) cnt[ix[a*6 +: 3]]++;
                    end
                end
                over = 1'b0;
                for (int b = 0; b < 8; b++) if (cnt[b] > 2) over = 1'b1;
                if (over) stop = 1'b1;
                else begin taken = cand; gr[i] = 1'b1; end
            end
        end
        return gr;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_out(input logic [3:0] v, input logic [7:0] n, input logic [47:0] ix,
                             input logic [3:0] e, input string tg);
        logic rv, rh;
        chk(tg, 64'(grant), 64'(e), "grant");
        chk("R7", 64'(stall), 64'(|(v & ~e)), "stall");
        for (int g = 0; g < 8; g++) begin
            rv = n[g] & e[g/2];
            chk("R5", 64'(rd_vld[g]), 64'(rv), "rd_vld");
            if (rv) begin
                chk("R1", 64'(rd_bank[g*3 +: 3]), 64'(ix[g*6 +: 3]), "bank");
                chk("R2", 64'(rd_data[g*32 +: 32]), 64'(regval(int'(ix[g*6 +: 6]))), "data");
            end else begin
                chk("R5", 64'(rd_data[g*32 +: 32]), 64'h0, "idle data");
            end
        end
        for (int g = 0; g < 8; g++) begin
            for (int h = g + 1; h < 8; h++) begin
                rv = n[g] & e[g/2];
                rh = n[h] & e[h/2];
                if (rv && rh && ix[g*6 +: 3] == ix[h*6 +: 3]) begin
                    if (ix[g*6 +: 6] == ix[h*6 +: 6])
                        chk("R4", 64'(rd_lport[g] == rd_lport[h]), 64'h1, "shared port");
                    else
                        chk("R3", 64'(rd_lport[g] == rd_lport[h]), 64'h0, "distinct ports");
                end
            end
        end
    endtask

    task automatic run_group(input logic [3:0] v, input logic [7:0] n, input logic [47:0] ix,
                             input logic [3:0] e, input string tg, input string rtg);
        logic [3:0] rem, ex;
        int guard;
        @(negedge clk);
        in_vld = v; in_need = n; in_idx = ix;
        #5;
        chk("R8", 64'(acc_rdy), 64'h1, "ready for new group");
        check_out(v, n, ix, e, tg);
        rem = v & ~e;
        guard = 0;
        while (rem != 0 && guard < 8) begin
            @(negedge clk);
            in_vld = 4'hF; in_need = 8'hFF; in_idx = ~ix;   // must be ignored
            #5;
            chk("R8", 64'(acc_rdy), 64'h0, "ready during replay");
            ex = model(rem, n, ix);
            check_out(rem, n, ix, ex, rtg);
            rem = rem & ~ex;
            guard++;
        end
        @(negedge clk);
        in_vld = '0;
        #5;
        chk("R7", 64'(acc_rdy), 64'h1, "ready after remainder");
    endtask

    task automatic write2(input int a, input logic [31:0] da, input int b, input logic [31:0] db);
        @(negedge clk);
        wr_en = 2'b11;
        wr_idx = {6'(b), 6'(a)};
        wr_data = {db, da};
        @(negedge clk);
        wr_en = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] v, e, m;
        logic [7:0] n;
        logic [47:0] ix;
        repeat (3) @(negedge clk);
        #5;
        // R10 reset state
        chk("R10", 64'(acc_rdy), 64'h1, "reset ready");
        chk("R10", 64'(grant), 64'h0, "reset grant");
        chk("R10", 64'(stall), 64'h0, "reset stall");
        chk("R10", 64'(rd_vld), 64'h0, "reset rd_vld");
        @(negedge clk);
        rst_n = 1'b1;
        in_vld = 4'h1; in_need = 8'h01; in_idx = 48'o11;
        #5;
        chk("R10", 64'(rd_data[31:0]), 64'h0, "cleared storage");
        @(negedge clk);
        in_vld = '0;

        // R11 write-port priority
        write2(5, 32'hAAAA_0001, 5, 32'hBBBB_0002);
        @(negedge clk);
        in_vld = 4'h1; in_need = 8'h01; in_idx = 48'o05;
        #5;
        chk("R11", 64'(rd_data[31:0]), 64'hBBBB_0002, "higher port wins");
        @(negedge clk);
        in_vld = '0;

        for (int r = 0; r < 64; r += 2) write2(r, regval(r), r + 1, regval(r + 1));

        for (int k = 0; k < 6; k++) begin
            run_group(VEC[k][63:60], VEC[k][59:52], VEC[k][51:4], VEC[k][3:0], "R6", "R8");
        end
        // R12 invalid slots neither granted nor blocking
        run_group(4'hA, 8'hFF, 48'o0706524232221202, 4'hA, "R12", "R8");
        // R9 replay heads with both sources in one bank
        run_group(4'hF, 8'hFF, 48'o7767574737271707, 4'h1, "R6", "R9");
        run_group(4'hF, 8'hFF, 48'o7161514131211111, 4'h1, "R6", "R9");

        // random groups against the reference model
        for (int k = 0; k < 150; k++) begin
            v = 4'($urandom);
            n = 8'($urandom);
            for (int g = 0; g < 8; g++) ix[g*6 +: 6] = 6'($urandom_range(0, 23));
            m = model(v, n, ix);
            e = m;
            run_group(v, n, ix, e, "R6", "R8");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule